// File: doc/BRIEF.md
# Command FIFO Status Engine

This block is the device side of a memory-mapped command channel. A host moves bytes one at a time through a single data port. While a command is being loaded, writes to that port fill an internal buffer. Once a response exists, reads from the same port drain it. A status byte lets the host ask for the ready state, start execution, replay a response, and see when more command bytes are needed or when response data is waiting. A 16-bit burst count tells the host how many bytes it can move before it has to poll again.

Execution is modelled by a stub. After a fixed number of cycles, it hands back a response that is the received command with every byte XORed by a constant. Command length comes from a big-endian 32-bit size field in bytes 2 to 5 of the command. The host can abort a running command through a write-only cancel bit in the byte that follows the burst count.

Top module: `cmd_status_engine`

## Requirements
- R1: After reset the status byte (offset 0x18) reads 0x80: bit 7 valid set, all other bits clear. The burst count reads 0, and offset 0x1B reads 0x00. The go (bit 5) and retry (bit 1) bits always read 0.
- R2: Writing a status byte with bit 6 set, in any state except executing, enters the ready state and discards any buffered command or response. Status then reads 0xC0.
- R3: A write to the data port (offset 0x24) in the ready or receiving state stores one command byte. The first byte moves the block to receiving, with ready reading 0 and expect (bit 3) reading 1. Data-port writes in the idle, executing or complete state are ignored.
- R4: Expect stays 1 until at least 6 bytes have arrived and the byte count has reached the big-endian size in bytes 2–5, with that size limited to the 1280-byte buffer. After that, further data-port writes are ignored.
- R5: Writing bit 5 of the status byte starts execution only in receiving with expect 0. Otherwise the write is ignored. Status reads 0x80 while executing. EXEC_CYCLES cycles later, status reads 0x90 (data available, bit 4).
- R6: The burst count is read as a low byte at 0x19 and a high byte at 0x1A, each as its own byte access. It is 0 in idle and executing. In ready and receiving it is the free buffer space, and in complete it is the unread response bytes. In every state it is limited to BURST_CAP (64).
- R7: The response is as long as the received command, and byte i equals command byte i XOR 0xA5. Reads in complete return it in order. After the last byte, data available drops, and further reads return 0xFF without advancing.
- R8: Writing bit 1 of the status byte in complete replays the response from its first byte.
- R9: Writing bit 0 of offset 0x1B while executing aborts the command and enters the ready state (0xC0). No response is produced afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| bus_addr | input | AW (12) | Byte address of the access |
| bus_wr | input | 1 | Write strobe, one byte per cycle |
| bus_rd | input | 1 | Read strobe; consumes a response byte at the data port |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed byte, valid in the same cycle |

## Verification
The assertions check on every cycle that the byte count never passes the buffer size and that the read pointer never passes the response length. They also check that the burst count stays within its cap, that execution only begins from a complete command, and that the executor is busy whenever the engine is executing. A retry must leave the read pointer at zero. Only the bench scenarios can show the end-to-end behaviour. This covers the exact status values through each handshake, the ignored writes, the size-field decoding including an oversized size, and the XORed byte order of a response and its replay. It also covers cancellation leaving no response behind.

// File: rtl/cse_pkg.sv
package cse_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READY,
    ST_RECV,
    ST_EXEC,
    ST_DONE
  } eng_state_t;

  localparam logic [11:0] OFS_STATUS  = 12'h018;
  localparam logic [11:0] OFS_BURST_L = 12'h019;
  localparam logic [11:0] OFS_BURST_H = 12'h01A;
  localparam logic [11:0] OFS_EXTRA   = 12'h01B;
  localparam logic [11:0] OFS_DATA    = 12'h024;

  localparam int BIT_VALID = 7;
  localparam int BIT_RDY   = 6;
  localparam int BIT_GO    = 5;
  localparam int BIT_AVAIL = 4;
  localparam int BIT_EXPCT = 3;
  localparam int BIT_RETRY = 1;
  localparam int BIT_ABORT = 0;

  localparam int HDR_BYTES = 6;
endpackage

// File: rtl/cse_buffer.sv
module cse_buffer #(
  parameter int DEPTH = 1280,
  parameter int IW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [7:0]    wr_data,
  input  logic [IW-1:0] rd_idx,
  output logic [7:0]    rd_data
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem[wr_idx] <= wr_data;
    end
  end

  assign rd_data = mem[rd_idx];
endmodule

// File: rtl/cse_exec.sv
module cse_exec #(
  parameter int DELAY = 20,
  parameter int CW    = $clog2(DELAY + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic abort,
  output logic busy,
  output logic done
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          busy_q, busy_d;
  logic          en;

  assign done = busy_q && (cnt_q == CW'(DELAY - 1)) && !abort;
  assign busy = busy_q;

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    en     = 1'b0;
    if (abort) begin
      busy_d = 1'b0;
      en     = 1'b1;
    end else if (start) begin
      busy_d = 1'b1;
      cnt_d  = '0;
      en     = 1'b1;
    end else if (done) begin
      busy_d = 1'b0;
      en     = 1'b1;
    end else if (busy_q) begin
      cnt_d  = cnt_q + CW'(1);
      en     = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (en) begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
    end
  end

  AST_EXEC_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (cnt_q < CW'(DELAY))); // R5
endmodule

// File: rtl/cse_burst.sv
module cse_burst
  import cse_pkg::*;
#(
  parameter int DEPTH = 1280,
  parameter int CAP   = 64,
  parameter int IW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  eng_state_t    state,
  input  logic [IW-1:0] wr_cnt,
  input  logic [IW-1:0] rsp_len,
  input  logic [IW-1:0] rd_ptr,
  output logic [15:0]   burst
);
  logic [IW-1:0] raw;

  always_comb begin
    unique case (state)
      ST_READY, ST_RECV: raw = IW'(DEPTH) - wr_cnt;
      ST_DONE:           raw = rsp_len - rd_ptr;
      default:           raw = '0;
    endcase
  end

  assign burst = (raw > IW'(CAP)) ? 16'(CAP) : 16'(raw);

  AST_BURST_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    burst <= 16'(CAP)); // R6
endmodule

// File: rtl/cmd_status_engine.sv
module cmd_status_engine
  import cse_pkg::*;
#(
  parameter int         AW          = 12,
  parameter int         BUF_BYTES   = 1280,
  parameter int         BURST_CAP   = 64,
  parameter int         EXEC_CYCLES = 20,
  parameter logic [7:0] RSP_XOR     = 8'hA5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [7:0]    bus_wdata,
  output logic [7:0]    bus_rdata
);
  localparam int IW = $clog2(BUF_BYTES + 1);

  eng_state_t    state_q, state_d;
  logic [IW-1:0] wr_cnt_q, wr_cnt_d;
  logic [IW-1:0] rd_ptr_q, rd_ptr_d;
  logic [IW-1:0] rsp_len_q, rsp_len_d;
  logic [31:0]   size_q, size_d;
  logic          ctl_en;

  logic hit_sts, hit_bl, hit_bh, hit_ext, hit_dat;
  logic wr_sts;
  logic rdy_req, go_req, retry_req, cancel_req, push, pop;
  logic need_more, avail, expect_more, in_hdr;
  logic [IW-1:0] eff_len;
  logic exec_busy, exec_done;
  logic [7:0]  buf_byte, status_byte;
  logic [15:0] burst;

  assign hit_sts = (bus_addr == AW'(OFS_STATUS));
  assign hit_bl  = (bus_addr == AW'(OFS_BURST_L));
  assign hit_bh  = (bus_addr == AW'(OFS_BURST_H));
  assign hit_ext = (bus_addr == AW'(OFS_EXTRA));
  assign hit_dat = (bus_addr == AW'(OFS_DATA));
  assign wr_sts  = bus_wr && hit_sts;

  assign eff_len   = (size_q > 32'(BUF_BYTES)) ? IW'(BUF_BYTES) : size_q[IW-1:0];
  assign need_more = (wr_cnt_q < IW'(HDR_BYTES)) || (wr_cnt_q < eff_len);
  assign in_hdr    = (wr_cnt_q >= IW'(2)) && (wr_cnt_q <= IW'(5));
  assign avail     = (state_q == ST_DONE) && (rd_ptr_q < rsp_len_q);
  assign expect_more = (state_q == ST_RECV) && need_more;

  assign rdy_req    = wr_sts && bus_wdata[BIT_RDY] && (state_q != ST_EXEC);
  assign cancel_req = bus_wr && hit_ext && bus_wdata[BIT_ABORT] && (state_q == ST_EXEC);
  assign go_req     = wr_sts && bus_wdata[BIT_GO] && (state_q == ST_RECV) && !need_more;
  assign retry_req  = wr_sts && bus_wdata[BIT_RETRY] && (state_q == ST_DONE) && !rdy_req;
  assign push       = bus_wr && hit_dat &&
                      ((state_q == ST_READY) || ((state_q == ST_RECV) && need_more));
  assign pop        = bus_rd && hit_dat && avail;

  always_comb begin
    state_d   = state_q;
    wr_cnt_d  = wr_cnt_q;
    rd_ptr_d  = rd_ptr_q;
    rsp_len_d = rsp_len_q;
    size_d    = size_q;
    ctl_en    = 1'b1;
    if (rdy_req || cancel_req) begin
      state_d   = ST_READY;
      wr_cnt_d  = '0;
      rd_ptr_d  = '0;
      rsp_len_d = '0;
      size_d    = '0;
    end else if (push) begin
      state_d  = ST_RECV;
      wr_cnt_d = wr_cnt_q + IW'(1);
      if (in_hdr) begin
        size_d = {size_q[23:0], bus_wdata};
      end
    end else if (go_req) begin
      state_d   = ST_EXEC;
      rsp_len_d = wr_cnt_q;
    end else if (exec_done) begin
      state_d  = ST_DONE;
      rd_ptr_d = '0;
    end else if (retry_req) begin
      rd_ptr_d = '0;
    end else if (pop) begin
      rd_ptr_d = rd_ptr_q + IW'(1);
    end else begin
      ctl_en = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      wr_cnt_q  <= '0;
      rd_ptr_q  <= '0;
      rsp_len_q <= '0;
      size_q    <= '0;
    end else if (ctl_en) begin
      state_q   <= state_d;
      wr_cnt_q  <= wr_cnt_d;
      rd_ptr_q  <= rd_ptr_d;
      rsp_len_q <= rsp_len_d;
      size_q    <= size_d;
    end
  end

  cse_buffer #(.DEPTH(BUF_BYTES), .IW(IW)) u_buf (
    .clk     (clk),
    .wr_en   (push),
    .wr_idx  (wr_cnt_q),
    .wr_data (bus_wdata),
    .rd_idx  (rd_ptr_q),
    .rd_data (buf_byte)
  );

  cse_exec #(.DELAY(EXEC_CYCLES)) u_exec (
    .clk   (clk),
    .rst_n (rst_n),
    .start (go_req),
    .abort (cancel_req),
    .busy  (exec_busy),
    .done  (exec_done)
  );

  cse_burst #(.DEPTH(BUF_BYTES), .CAP(BURST_CAP), .IW(IW)) u_burst (
    .clk     (clk),
    .rst_n   (rst_n),
    .state   (state_q),
    .wr_cnt  (wr_cnt_q),
    .rsp_len (rsp_len_q),
    .rd_ptr  (rd_ptr_q),
    .burst   (burst)
  );

  always_comb begin
    status_byte            = '0;
    status_byte[BIT_VALID] = 1'b1;
    status_byte[BIT_RDY]   = (state_q == ST_READY);
    status_byte[BIT_AVAIL] = avail;
    status_byte[BIT_EXPCT] = expect_more;
  end

  always_comb begin
    if (hit_sts)      bus_rdata = status_byte;
    else if (hit_bl)  bus_rdata = burst[7:0];
    else if (hit_bh)  bus_rdata = burst[15:8];
    else if (hit_ext) bus_rdata = 8'h00;
    else if (hit_dat) bus_rdata = avail ? (buf_byte ^ RSP_XOR) : 8'hFF;
    else              bus_rdata = 8'h00;
  end

  AST_CNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cnt_q <= IW'(BUF_BYTES)); // R4
  AST_RDPTR_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ptr_q <= rsp_len_q); // R7
  AST_GO_FULL_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_EXEC && $past(state_q) == ST_RECV) |-> !$past(need_more)); // R5
  AST_EXEC_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_EXEC) |-> exec_busy); // R9
  AST_RETRY_REWIND: assert property (@(posedge clk) disable iff (!rst_n)
    retry_req |=> (rd_ptr_q == '0)); // R8
endmodule

// File: tb/cmd_status_engine_test.sv
`timescale 1ns/1ps
module cmd_status_engine_test;
  localparam int EXEC_CYCLES = 20;
  localparam logic [11:0] A_STS = 12'h018;
  localparam logic [11:0] A_BL  = 12'h019;
  localparam logic [11:0] A_BH  = 12'h01A;
  localparam logic [11:0] A_EXT = 12'h01B;
  localparam logic [11:0] A_DAT = 12'h024;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;

  int n_chk = 0;
  int n_fail = 0;
  logic [7:0] exp_q [$];
  string      tag_q [$];

  always #5 clk = ~clk;

  cmd_status_engine #(.EXEC_CYCLES(EXEC_CYCLES)) uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic bwr(input logic [11:0] a, input logic [7:0] d);
    @(posedge clk); #2;
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); #2;
    bus_wr = 1'b0;
  endtask

  task automatic rreg(input logic [11:0] a, output logic [7:0] d);
    @(posedge clk); #2;
    bus_addr = a; #3;
    d = bus_rdata;
  endtask

  task automatic chk_sts(input string tag, input int exp);
    logic [7:0] v;
    rreg(A_STS, v);
    chk(tag, v, exp);
  endtask

  task automatic chk_burst(input string tag, input int exp);
    logic [7:0] lo, hi;
    rreg(A_BL, lo);
    rreg(A_BH, hi);
    chk(tag, {hi, lo}, exp);
  endtask

  // driver side of the scoreboard: queue expectation, then issue the read
  task automatic fifo_rd(input string tag, input logic [7:0] exp);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(posedge clk); #2;
    bus_addr = A_DAT; bus_rd = 1'b1;
    @(posedge clk); #2;
    bus_rd = 1'b0;
  endtask

  // monitor side: compares each data-port read away from the active edge
  always @(negedge clk) begin
    if (bus_rd && bus_addr == A_DAT) begin
      if (exp_q.size() == 0) begin
        chk("R7 unexpected read", bus_rdata, 0);
      end else begin
        chk(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
      end
    end
  end

  initial begin
    #1_500_000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] cmd [10];
    logic [7:0] v;
    cmd = '{8'h80, 8'h01, 8'h00, 8'h00, 8'h00, 8'h0A, 8'h11, 8'h22, 8'h33, 8'h44};
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;

    chk_sts("R1 reset status", 8'h80);
    chk_burst("R1 reset burst", 0);
    rreg(A_EXT, v);
    chk("R1 ext byte", v, 8'h00);

    bwr(A_DAT, 8'h11);
    chk_sts("R3 write in idle ignored", 8'h80);

    bwr(A_STS, 8'h40);
    chk_sts("R2 ready status", 8'hC0);
    chk_burst("R6 burst capped in ready", 64);
    bwr(A_STS, 8'h20);
    chk_sts("R5 go in ready ignored", 8'hC0);

    bwr(A_DAT, cmd[0]);
    chk_sts("R3 first byte expect", 8'h88);
    bwr(A_STS, 8'h20);
    chk_sts("R5 go with expect ignored", 8'h88);
    for (int i = 1; i < 5; i++) bwr(A_DAT, cmd[i]);
    chk_sts("R4 expect held in header", 8'h88);
    for (int i = 5; i < 10; i++) bwr(A_DAT, cmd[i]);
    chk_sts("R4 expect cleared", 8'h80);
    bwr(A_DAT, 8'h99);

    bwr(A_STS, 8'h20);
    chk_sts("R5 executing status", 8'h80);
    chk_burst("R6 burst zero executing", 0);
    bwr(A_DAT, 8'h77);
    repeat (EXEC_CYCLES + 2) @(posedge clk);
    chk_sts("R5 response available", 8'h90);
    chk_burst("R4 extra write ignored, burst", 10);

    for (int i = 0; i < 3; i++) fifo_rd("R7 response byte", cmd[i] ^ 8'hA5);
    chk_burst("R6 burst unread", 7);
    for (int i = 3; i < 10; i++) fifo_rd("R7 response byte", cmd[i] ^ 8'hA5);
    chk_sts("R7 drained status", 8'h80);
    fifo_rd("R7 read past end", 8'hFF);
    chk_burst("R7 no advance past end", 0);

    bwr(A_STS, 8'h02);
    chk_sts("R8 retry status", 8'h90);
    chk_burst("R8 retry burst", 10);
    fifo_rd("R8 replay byte0", cmd[0] ^ 8'hA5);
    fifo_rd("R8 replay byte1", cmd[1] ^ 8'hA5);

    // cancel scenario
    bwr(A_STS, 8'h40);
    chk_sts("R2 ready from complete", 8'hC0);
    bwr(A_DAT, 8'h80); bwr(A_DAT, 8'h01); bwr(A_DAT, 8'h00);
    bwr(A_DAT, 8'h00); bwr(A_DAT, 8'h00); bwr(A_DAT, 8'h06);
    chk_sts("R4 six byte command done", 8'h80);
    bwr(A_STS, 8'h20);
    bwr(A_STS, 8'h40);
    chk_sts("R2 ready ignored while executing", 8'h80);
    bwr(A_EXT, 8'h01);
    chk_sts("R9 cancel to ready", 8'hC0);
    repeat (EXEC_CYCLES + 5) @(posedge clk);
    chk_sts("R9 no response after cancel", 8'hC0);
    chk_burst("R9 burst after cancel", 64);

    // oversized size field limited to the buffer
    bwr(A_DAT, 8'h80); bwr(A_DAT, 8'h01); bwr(A_DAT, 8'h00);
    bwr(A_DAT, 8'h00); bwr(A_DAT, 8'h10); bwr(A_DAT, 8'h00);
    for (int i = 6; i < 1250; i++) bwr(A_DAT, 8'(i));
    chk_sts("R4 oversized still expecting", 8'h88);
    chk_burst("R6 free space below cap", 30);
    for (int i = 1250; i < 1280; i++) bwr(A_DAT, 8'(i));
    chk_sts("R4 buffer full clears expect", 8'h80);
    chk_burst("R6 burst zero when full", 0);
    bwr(A_DAT, 8'h55);
    bwr(A_STS, 8'h20);
    repeat (EXEC_CYCLES + 2) @(posedge clk);
    chk_burst("R7 full response length capped", 64);
    fifo_rd("R7 big response byte0", 8'h80 ^ 8'hA5);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule